// File: doc/BRIEF.md
# Received Packet Type Classifier

This block watches the start of each received packet on a serial bit stream and identifies its kind from the two low-order bits of the packet identifier. The bits arrive one at a time under a bit-valid strobe, least significant first, after a start-of-packet pulse has armed the capture. When the second bit is accepted, the two-bit code sorts the packet into token, data or handshake.

The block then sets the matching sticky bit in a three-bit receive status word. In the next cycle it pulses one of two strobes toward the buffer pointer sequencer. The token strobe points the sequencer at the token store region. The data/handshake strobe points it at the receive data region, which data and handshake packets share. Software clears status bits through a per-bit clear mask. Later identifier bits, the rest of the packet, and any bits seen before a start-of-packet are ignored.

Top module: `pkt_class_top`

## Requirements
- R1: After reset the status word is 000 and both strobes are low. Bits that arrive before the first start-of-packet pulse have no effect.
- R2: A start-of-packet pulse arms the capture. The first accepted bit is identifier bit 0 and the second is bit 1. A bit that is valid in the same cycle as the start-of-packet pulse is accepted as bit 0.
- R3: Code {bit1,bit0} = 01 sets status bit 0 and pulses `tok_stb_o`.
- R4: Code 11 sets status bit 1 and pulses `rxd_stb_o`.
- R5: Code 10 sets status bit 2 and pulses `rxd_stb_o`.
- R6: Code 00 sets no status bit and pulses no strobe.
- R7: The status update and the strobe appear in the cycle after the clock edge that accepts bit 1. A strobe lasts exactly one cycle. Classification happens at most once per packet, and further bits are ignored until the next start-of-packet.
- R8: Status bits are sticky. A high bit in `stat_clr_i` clears the matching status bit. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: A start-of-packet pulse in the middle of a capture discards the bits taken so far and restarts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_vld_i | input | 1 | Serial bit valid strobe |
| bit_i | input | 1 | Serial data bit |
| sop_i | input | 1 | Start-of-packet pulse, arms identifier capture |
| stat_clr_i | input | 3 | Per-bit status clear mask |
| rx_stat_o | output | 3 | Sticky status: bit0 token, bit1 data, bit2 handshake |
| tok_stb_o | output | 1 | One-cycle token region strobe |
| rxd_stb_o | output | 1 | One-cycle receive data region strobe |

## Verification
The bench builds the block with its default parameters: a two-bit capture and a two-stage reset synchronizer. These defaults make every code value, the same-cycle start-of-packet and bit case, and a restart in the middle of a capture reachable within a few cycles. Random gaps in bit-valid and random clear masks drive set/clear collisions and back-to-back packets often enough to exercise the sticky-bit priority over thousands of cycles.

// File: rtl/pkt_cls_pkg.sv
package pkt_cls_pkg;
  localparam int STAT_W = 3;
  localparam int ST_TOK = 0;
  localparam int ST_DAT = 1;
  localparam int ST_HS  = 2;

  localparam logic [1:0] CODE_TOK = 2'b01;
  localparam logic [1:0] CODE_DAT = 2'b11;
  localparam logic [1:0] CODE_HS  = 2'b10;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_TOK  = 2'd1,
    CLS_DAT  = 2'd2,
    CLS_HS   = 2'd3
  } pkt_cls_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pid_capture.sv
module pid_capture #(
  parameter int CAP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [CAP_W-1:0] code_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(CAP_W + 1);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(CAP_W);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
  logic [CAP_W-1:0] cap_q, cap_d;
  logic             accept;
  logic             upd_en;

  always_comb begin
    cnt_base = sop ? '0 : cnt_q;
    accept   = bit_vld && (cnt_base < IDLE);
    cnt_d    = cnt_base;
    cap_d    = cap_q;
    if (accept) begin
      cnt_d = cnt_base + 1'b1;
      for (int i = 0; i < CAP_W; i++) begin
        if (cnt_base == CNT_W'(i)) cap_d[i] = bit_in;
      end
    end
    upd_en = sop | accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= IDLE;
      cap_q <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  assign code_o = cap_d;
  assign done_o = accept && (cnt_base == CNT_W'(CAP_W - 1));
endmodule

// File: rtl/pid_decode.sv
module pid_decode
  import pkt_cls_pkg::*;
(
  input  logic              done,
  input  logic [1:0]        code,
  output logic [STAT_W-1:0] set_vec,
  output logic              tok_hit,
  output logic              rxd_hit
);
  pkt_cls_e cls;

  always_comb begin
    cls = CLS_NONE;
    if (done) begin
      case (code)
        CODE_TOK: cls = CLS_TOK;
        CODE_DAT: cls = CLS_DAT;
        CODE_HS:  cls = CLS_HS;
        default:  cls = CLS_NONE;
      endcase
    end
    set_vec         = '0;
    set_vec[ST_TOK] = (cls == CLS_TOK);
    set_vec[ST_DAT] = (cls == CLS_DAT);
    set_vec[ST_HS]  = (cls == CLS_HS);
    tok_hit         = (cls == CLS_TOK);
    rxd_hit         = (cls == CLS_DAT) || (cls == CLS_HS);
  end
endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] stat_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic st_q, st_d, st_en;

    always_comb begin
      st_en = set_vec[g] | clr_vec[g];
      st_d  = set_vec[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= 1'b0;
      else if (st_en) st_q <= st_d;
    end

    assign stat_o[g] = st_q;
  end
endmodule

// File: rtl/pkt_class_top.sv
module pkt_class_top
  import pkt_cls_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              sop_i,
  input  logic [STAT_W-1:0] stat_clr_i,
  output logic [STAT_W-1:0] rx_stat_o,
  output logic              tok_stb_o,
  output logic              rxd_stb_o
);
  localparam int CAP_W = 2;

  logic              rst_n_s;
  logic [CAP_W-1:0]  code;
  logic              done;
  logic [STAT_W-1:0] set_vec;
  logic              tok_hit, rxd_hit;
  logic              tok_q, rxd_q, tok_d, rxd_d;

  rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pid_capture #(.CAP_W(CAP_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .sop     (sop_i),
    .bit_vld (bit_vld_i),
    .bit_in  (bit_i),
    .code_o  (code),
    .done_o  (done)
  );

  pid_decode u_dec (
    .done    (done),
    .code    (code),
    .set_vec (set_vec),
    .tok_hit (tok_hit),
    .rxd_hit (rxd_hit)
  );

  rx_status #(.W(STAT_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_vec (set_vec),
    .clr_vec (stat_clr_i),
    .stat_o  (rx_stat_o)
  );

  always_comb begin
    tok_d = tok_hit;
    rxd_d = rxd_hit;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      tok_q <= 1'b0;
      rxd_q <= 1'b0;
    end else begin
      tok_q <= tok_d;
      rxd_q <= rxd_d;
    end
  end

  assign tok_stb_o = tok_q;
  assign rxd_stb_o = rxd_q;
endmodule

// File: rtl/pkt_class_chk.sv
module pkt_class_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_vld_i,
  input logic [2:0] stat_clr_i,
  input logic [2:0] rx_stat_o,
  input logic       tok_stb_o,
  input logic       rxd_stb_o
);
  assert_one_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tok_stb_o, rxd_stb_o}));

  assert_tok_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tok_stb_o |=> !tok_stb_o);

  assert_rxd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_stb_o |=> !rxd_stb_o);

  assert_strobe_after_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_stb_o || rxd_stb_o) |-> $past(bit_vld_i));

  assert_tok_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tok_stb_o |-> rx_stat_o[0]);

  assert_rxd_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_stb_o |-> (rx_stat_o[1] || rx_stat_o[2]));

  assert_tok_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_stat_o[0]) |-> tok_stb_o);

  assert_hs_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_stat_o[2]) |-> rxd_stb_o);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rx_stat_o & $past(rx_stat_o & ~stat_clr_i)) == $past(rx_stat_o & ~stat_clr_i)));
endmodule

bind pkt_class_top pkt_class_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_vld_i  (bit_vld_i),
  .stat_clr_i (stat_clr_i),
  .rx_stat_o  (rx_stat_o),
  .tok_stb_o  (tok_stb_o),
  .rxd_stb_o  (rxd_stb_o)
);

// File: tb/test_pkt_class_top.sv
module test_pkt_class_top;
  logic       clk;
  logic       rst_n;
  logic       bit_vld_i, bit_i, sop_i;
  logic [2:0] stat_clr_i;
  logic [2:0] rx_stat_o;
  logic       tok_stb_o, rxd_stb_o;

  int checks = 0;
  int errors = 0;

  // bench model state
  int         m_cnt;
  logic       m_b0;
  logic [2:0] m_stat;
  logic       m_tok, m_rxd;

  pkt_class_top i_pkt_class_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .sop_i      (sop_i),
    .stat_clr_i (stat_clr_i),
    .rx_stat_o  (rx_stat_o),
    .tok_stb_o  (tok_stb_o),
    .rxd_stb_o  (rxd_stb_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // status bit for a code: 01 -> bit0, 11 -> bit1, 10 -> bit2, 00 -> none
  function automatic logic [2:0] cls_bits(input logic [1:0] code);
    case (code)
      2'b01:   return 3'b001;
      2'b11:   return 3'b010;
      2'b10:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(input string tag);
    logic [4:0] act, exp;
    act = {rx_stat_o, tok_stb_o, rxd_stb_o};
    exp = {m_stat, m_tok, m_rxd};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {stat,tok,rxd} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic s, input logic v, input logic b, input logic [2:0] c);
    logic [2:0] setb;
    setb  = 3'b000;
    m_tok = 1'b0;
    m_rxd = 1'b0;
    if (s) m_cnt = 0;
    if (v && m_cnt < 2) begin
      if (m_cnt == 0) begin
        m_b0  = b;
        m_cnt = 1;
      end else begin
        setb  = cls_bits({b, m_b0});
        m_tok = setb[0];
        m_rxd = setb[1] | setb[2];
        m_cnt = 2;
      end
    end
    m_stat = (m_stat & ~c) | setb;
  endtask

  task automatic step(input logic s, input logic v, input logic b,
                      input logic [2:0] c, input string tag);
    @(negedge clk);
    sop_i = s; bit_vld_i = v; bit_i = b; stat_clr_i = c;
    @(posedge clk);
    model_edge(s, v, b, c);
    #2;
    chk(tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));
    rst_n = 1'b0; sop_i = 0; bit_vld_i = 0; bit_i = 0; stat_clr_i = 0;
    m_cnt = 2; m_b0 = 0; m_stat = 0; m_tok = 0; m_rxd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset state");

    // R1: bits with no start-of-packet are ignored
    step(0, 1, 1, 3'b000, "R1");
    step(0, 1, 0, 3'b000, "R1");
    step(0, 1, 1, 3'b000, "R1");

    // R2/R3: bit valid with sop is bit0; code 01 -> token
    step(1, 1, 1, 3'b000, "R2");
    step(0, 1, 0, 3'b000, "R3 token");
    step(0, 1, 1, 3'b000, "R7 third bit ignored");
    step(0, 1, 1, 3'b000, "R7 strobe one cycle");

    // R4: sop alone, a gap, then 1,1 -> data
    step(1, 0, 0, 3'b000, "R2");
    step(0, 0, 1, 3'b000, "R2 gap");
    step(0, 1, 1, 3'b000, "R4");
    step(0, 1, 1, 3'b000, "R4 data");
    step(0, 0, 0, 3'b000, "R7");

    // R5: bit0 = 0, bit1 = 1 -> handshake
    step(1, 0, 0, 3'b000, "R5");
    step(0, 1, 0, 3'b000, "R5");
    step(0, 1, 1, 3'b000, "R5 handshake");

    // R8: clear everything, then R6 code 00 does nothing
    step(0, 0, 0, 3'b111, "R8 clear");
    step(1, 1, 0, 3'b000, "R6");
    step(0, 1, 0, 3'b000, "R6 code 00");
    step(0, 0, 0, 3'b000, "R6");

    // R9: restart mid-capture; without it code would be 10
    step(1, 1, 0, 3'b000, "R9");
    step(1, 1, 1, 3'b000, "R9 restart");
    step(0, 1, 1, 3'b000, "R9 data after restart");

    // R8: set and clear of the same bit in one cycle, set wins
    step(1, 1, 1, 3'b000, "R8");
    step(0, 1, 0, 3'b001, "R8 set beats clear");
    step(0, 0, 0, 3'b001, "R8 clear alone");
    step(0, 0, 0, 3'b010, "R8 clear data bit");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic s, v, b;
      logic [2:0] c;
      s = ($urandom % 8) == 0;
      v = ($urandom % 10) < 7;
      b = $urandom % 2;
      c = (($urandom % 12) == 0) ? 3'($urandom) : 3'b000;
      step(s, v, b, c, "R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule